// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-facing register file of a two-channel serial communications controller. A CPU reaches it over a byte-wide bus with a 3-bit address. Each channel presents a control port and a data port. The control port is pointer-indirect. The first control write selects a register. The next control access, read or write, goes to that register. After that access the pointer falls back to register 0. The data port carries received bytes to the host and transmit bytes to the line side.

On the line side, each channel takes received bytes and break events on a valid/ready style handshake. It emits transmit bytes on a one-cycle strobe and learns that the transmitter has drained from a `tx_done` pulse. The block does not generate baud rates, serialise bits or run synchronous modes.

All channel interrupts are merged into one combinational request line. Each channel's contribution is gated by its own master enable and is built from three sources: transmit-empty, received character and break.

Pointer state machine, one per channel:
- States: `PTR_HOME` (pointer 0) and `PTR_ARMED` (pointer holds a register index).
- Transition `PTR_HOME -> PTR_ARMED`: a control write whose low nibble is nonzero.
- Transition `PTR_ARMED -> PTR_HOME`: any control read or control write.
- Transition `any -> PTR_HOME`: a channel reset.

Top module: `dual_sio_regs`

## Requirements
- R1: Address bit 2 picks the channel (0 = first, 1 = second). Address bit 1 picks control (0) or data (1). Address bit 0 has no effect.
- R2: In `PTR_HOME`, a control write stores the byte in write register 0 and loads the pointer from data bits 3:0. The next control access uses that register, then the pointer returns to 0. In `PTR_HOME`, a control read returns status register 0.
- R3: After reset, status register 0 of each channel reads 0x04 (bit 2 = transmit empty), and irq, rx_ready and tx_strobe are all low.
- R4: A write to register 9 acts on bits 7:6 as a reset command: 01 resets the second channel, 10 the first, 11 both, and 00 neither. A channel reset clears its write registers, its pending flags, its received character and its pointer, and sets status register 0 to 0x04.
- R5: A data-port write raises tx_strobe for exactly one cycle, in the cycle after the write, with the byte on that channel's tx_data lane. This happens only when write register 5 bit 3 is set; otherwise the write has no effect.
- R6: rx_ready is high only when write register 3 bit 0 is set and status bit 0 (character available) is clear. An accepted byte sets status bit 0 and the receive-pending flag.
- R7: A data-port read returns the received byte and clears status bit 0 and receive-pending. Read register 8 returns the same byte through the control port.
- R8: A channel contributes to irq only when its write register 1 bit 0 is set.
- R9: tx_done sets transmit-pending and status bit 2. An enabled data-port write clears both. Transmit-pending raises irq when write register 1 bit 1 is set.
- R10: Receive-pending raises irq only when write register 1 bits 4:3 are 01 or 10. The values 00 and 11 never do.
- R11: rx_break sets status bit 7, which raises irq when write register 15 bit 7 is set. A control read of status register 0 returns bit 7 and then clears it.
- R12: irq follows pending state combinationally. It changes in the cycle right after the edge that accepts a byte or a break, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address: channel, control/data, ignored bit |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the address is held |
| rx_valid | input | 2 | Per-channel received byte offered |
| rx_data | input | 16 | Received byte lanes, channel 0 in bits 7:0 |
| rx_ready | output | 2 | Per-channel receiver can take a byte |
| rx_break | input | 2 | Per-channel break event pulse |
| tx_done | input | 2 | Per-channel transmitter idle pulse |
| tx_strobe | output | 2 | Per-channel one-cycle transmit strobe |
| tx_data | output | 16 | Transmit byte lanes, channel 0 in bits 7:0 |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default widths: an 8-bit byte and 16 registers per channel. With these values the 4-bit pointer covers the full range of register indices, including the reset command register 9 and the break enable register 15. Every receive-mode encoding in write register 1 can be swept, and the channel reset commands can be checked against status bits that the host can read back. With both channels present, the bench can confirm that a reset aimed at one channel leaves the other channel's pending character and enables in place.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int NCH         = 2;
    localparam int IE_REG      = 1;
    localparam int RXCFG_REG   = 3;
    localparam int TXCFG_REG   = 5;
    localparam int RXBUF_REG   = 8;
    localparam int RST_REG     = 9;
    localparam int EXTIE_REG   = 15;

    typedef enum logic [0:0] {
        PTR_HOME  = 1'b0,
        PTR_ARMED = 1'b1
    } ptr_state_e;
endpackage

// File: rtl/sio_ptr_fsm.sv
module sio_ptr_fsm
    import sio_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] ptr
);
    ptr_state_e       state_q, state_d;
    logic [PTR_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_HOME;
            idx_q   <= '0;
        end else if (clr) begin
            state_q <= PTR_HOME;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            PTR_HOME: begin
                if (ctl_wr && (wr_idx != '0)) begin
                    state_d = PTR_ARMED;
                    idx_d   = wr_idx;
                end
            end
            PTR_ARMED: begin
                if (ctl_wr || ctl_rd) begin
                    state_d = PTR_HOME;
                    idx_d   = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        ptr = (state_q == PTR_ARMED) ? idx_q : '0;
    end
endmodule

// File: rtl/sio_chan.sv
module sio_chan
    import sio_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NREG   = 16,
    localparam int PTR_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_break,
    input  logic              tx_done,
    output logic [BYTE_W-1:0] ctl_rdata,
    output logic [BYTE_W-1:0] dat_rdata,
    output logic              rst_cmd_vld,
    output logic [1:0]        rst_cmd,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    logic [BYTE_W-1:0] wreg_q [NREG];
    logic [BYTE_W-1:0] rxbuf_q, txbuf_q, status;
    logic              char_q, txe_q, brk_q, rxp_q, txp_q, strobe_q;
    logic [PTR_W-1:0]  ptr;
    logic              accept, tx_go, stat_rd;
    logic [1:0]        rx_mode;
    logic              rx_src, tx_src, brk_src;

    sio_ptr_fsm #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (chan_rst),
        .ctl_wr (ctl_wr),
        .ctl_rd (ctl_rd),
        .wr_idx (wdata[PTR_W-1:0]),
        .ptr    (ptr)
    );

    assign rx_ready    = wreg_q[RXCFG_REG][0] & ~char_q;
    assign accept      = rx_valid & rx_ready;
    assign tx_go       = dat_wr & wreg_q[TXCFG_REG][3];
    assign stat_rd     = ctl_rd && (ptr == '0);
    assign rst_cmd_vld = ctl_wr && (ptr == PTR_W'(RST_REG));
    assign rst_cmd     = wdata[BYTE_W-1 -: 2];

    always_comb begin
        status           = '0;
        status[0]        = char_q;
        status[2]        = txe_q;
        status[BYTE_W-1] = brk_q;
    end

    always_comb begin
        ctl_rdata = '0;
        if (ptr == '0)
            ctl_rdata = status;
        else if (ptr == PTR_W'(RXBUF_REG))
            ctl_rdata = rxbuf_q;
    end

    assign dat_rdata = rxbuf_q;
    assign tx_strobe = strobe_q;
    assign tx_data   = txbuf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) wreg_q[i] <= '0;
            rxbuf_q  <= '0;
            txbuf_q  <= '0;
            char_q   <= 1'b0;
            txe_q    <= 1'b1;
            brk_q    <= 1'b0;
            rxp_q    <= 1'b0;
            txp_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else if (chan_rst) begin
            for (int i = 0; i < NREG; i++) wreg_q[i] <= '0;
            rxbuf_q  <= '0;
            char_q   <= 1'b0;
            txe_q    <= 1'b1;
            brk_q    <= 1'b0;
            rxp_q    <= 1'b0;
            txp_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            if (ctl_wr) wreg_q[ptr] <= wdata;

            if (accept) begin
                rxbuf_q <= rx_data;
                char_q  <= 1'b1;
                rxp_q   <= 1'b1;
            end else if (dat_rd) begin
                char_q  <= 1'b0;
                rxp_q   <= 1'b0;
            end

            if (tx_go) begin
                txp_q <= 1'b0;
                txe_q <= 1'b0;
            end else if (tx_done) begin
                txp_q <= 1'b1;
                txe_q <= 1'b1;
            end

            if (rx_break)     brk_q <= 1'b1;
            else if (stat_rd) brk_q <= 1'b0;

            strobe_q <= tx_go;
            if (tx_go) txbuf_q <= wdata;
        end
    end

    assign rx_mode = wreg_q[IE_REG][4:3];
    assign rx_src  = ((rx_mode == 2'b01) || (rx_mode == 2'b10)) && rxp_q;
    assign tx_src  = wreg_q[IE_REG][1] & txp_q;
    assign brk_src = wreg_q[EXTIE_REG][BYTE_W-1] & brk_q;
    assign irq     = wreg_q[IE_REG][0] & (rx_src | tx_src | brk_src);
endmodule

// File: rtl/dual_sio_regs.sv
module dual_sio_regs
    import sio_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NREG   = 16,
    localparam int LANES = NCH * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NCH-1:0]   rx_valid,
    input  logic [LANES-1:0] rx_data,
    output logic [NCH-1:0]   rx_ready,
    input  logic [NCH-1:0]   rx_break,
    input  logic [NCH-1:0]   tx_done,
    output logic [NCH-1:0]   tx_strobe,
    output logic [LANES-1:0] tx_data,
    output logic             irq
);
    logic              ch_sel, is_dat, rd_ok, unused_addr_bit;
    logic [NCH-1:0]    cmd_vld, chan_rst, irq_v;
    logic [1:0]        cmd    [NCH];
    logic [BYTE_W-1:0] ctl_rv [NCH];
    logic [BYTE_W-1:0] dat_rv [NCH];

    assign ch_sel          = bus_addr[2];
    assign is_dat          = bus_addr[1];
    assign unused_addr_bit = bus_addr[0];
    assign rd_ok           = bus_rd & ~bus_wr;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic sel;
        assign sel = (ch_sel == 1'(g));
        sio_chan #(.BYTE_W(BYTE_W), .NREG(NREG)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .chan_rst    (chan_rst[g]),
            .ctl_wr      (bus_wr & sel & ~is_dat),
            .ctl_rd      (rd_ok & sel & ~is_dat),
            .dat_wr      (bus_wr & sel & is_dat),
            .dat_rd      (rd_ok & sel & is_dat),
            .wdata       (bus_wdata),
            .rx_valid    (rx_valid[g]),
            .rx_data     (rx_data[g*BYTE_W +: BYTE_W]),
            .rx_break    (rx_break[g]),
            .tx_done     (tx_done[g]),
            .ctl_rdata   (ctl_rv[g]),
            .dat_rdata   (dat_rv[g]),
            .rst_cmd_vld (cmd_vld[g]),
            .rst_cmd     (cmd[g]),
            .rx_ready    (rx_ready[g]),
            .tx_strobe   (tx_strobe[g]),
            .tx_data     (tx_data[g*BYTE_W +: BYTE_W]),
            .irq         (irq_v[g])
        );
    end

    // command bit 1 hits the first channel, bit 0 the second
    always_comb begin
        chan_rst = '0;
        for (int c = 0; c < NCH; c++) begin
            if (cmd_vld[c]) begin
                if (cmd[c][1]) chan_rst[0] = 1'b1;
                if (cmd[c][0]) chan_rst[1] = 1'b1;
            end
        end
    end

    assign bus_rdata = is_dat ? dat_rv[ch_sel] : ctl_rv[ch_sel];
    assign irq       = |irq_v;
endmodule

// File: rtl/dual_sio_regs_chk.sv
module dual_sio_regs_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [1:0]        rx_valid,
    input logic [1:0]        rx_ready,
    input logic [1:0]        tx_strobe,
    input logic [2*BYTE_W-1:0] tx_data
);
    // R5
    tx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_strobe));

    // R5
    tx_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe != 2'b00) |-> $past(bus_wr && bus_addr[1]));

    // R5
    tx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe[0] |-> (tx_data[BYTE_W-1:0] == $past(bus_wdata)));

    // R1
    tx_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe[1] |-> $past(bus_addr[2]));

    // R6
    rx_take0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid[0] && rx_ready[0]) |=> !rx_ready[0]);

    // R6
    rx_take1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid[1] && rx_ready[1]) |=> !rx_ready[1]);
endmodule

bind dual_sio_regs dual_sio_regs_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_strobe (tx_strobe),
    .tx_data   (tx_data)
);

// File: tb/test_dual_sio_regs.sv
module test_dual_sio_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_valid = '0, rx_break = '0, tx_done = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_ready, tx_strobe;
    logic [15:0] tx_data;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    dual_sio_regs i_dual_sio_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_break(rx_break), .tx_done(tx_done), .tx_strobe(tx_strobe),
        .tx_data(tx_data), .irq(irq)
    );

    // {is_read, addr, wdata, expected read}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 3'd0, 8'h00, 8'h04},
        {1'b1, 3'd4, 8'h00, 8'h04},
        {1'b0, 3'd1, 8'h08, 8'h00},
        {1'b1, 3'd0, 8'h00, 8'h00},
        {1'b1, 3'd1, 8'h00, 8'h04},
        {1'b0, 3'd5, 8'h03, 8'h00},
        {1'b1, 3'd4, 8'h00, 8'h00},
        {1'b1, 3'd4, 8'h00, 8'h04},
        {1'b1, 3'd6, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wreg(input int ch, input logic [3:0] idx, input logic [7:0] v);
        bus_write({ch[0], 2'b00}, {4'h0, idx});
        bus_write({ch[0], 2'b00}, v);
    endtask

    task automatic rreg(input int ch, input logic [3:0] idx, output logic [7:0] d);
        if (idx != 4'h0) bus_write({ch[0], 2'b00}, {4'h0, idx});
        bus_read({ch[0], 2'b00}, d);
    endtask

    task automatic rx_push(input int ch, input logic [7:0] d);
        @(negedge clk); rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = d;
        @(negedge clk); rx_valid[ch] = 1'b0;
    endtask

    task automatic pulse_done(input int ch);
        @(negedge clk); tx_done[ch] = 1'b1;
        @(negedge clk); tx_done[ch] = 1'b0;
    endtask

    task automatic pulse_break(input int ch);
        @(negedge clk); rx_break[ch] = 1'b1;
        @(negedge clk); rx_break[ch] = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        // R3 outputs while reset is held
        repeat (2) @(negedge clk);
        check("R3 irq", {15'd0, irq}, 16'd0);
        check("R3 rx_ready", {14'd0, rx_ready}, 16'd0);
        check("R3 tx_strobe", {14'd0, tx_strobe}, 16'd0);
        rst_n = 1'b1;

        // vector table: R1 R2 R3 addressing and pointer walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) begin
                bus_read(VEC[i][18:16], d);
                check($sformatf("R2 vector %0d", i), {8'd0, d}, {8'd0, VEC[i][7:0]});
            end else begin
                bus_write(VEC[i][18:16], VEC[i][15:8]);
            end
        end

        // R6 R7 receive path on channel 0
        wreg(0, 4'd3, 8'h01);
        check("R6 ready on enable", {14'd0, rx_ready}, 16'b01);
        rx_push(0, 8'hA5);
        check("R6 ready drops", {14'd0, rx_ready}, 16'b00);
        rreg(0, 4'd0, d);
        check("R6 char available", {8'd0, d}, 16'h05);
        rreg(0, 4'd8, d);
        check("R7 read reg 8", {8'd0, d}, 16'hA5);
        bus_read(3'b011, d);
        check("R7 data read", {8'd0, d}, 16'hA5);
        rreg(0, 4'd0, d);
        check("R7 char cleared", {8'd0, d}, 16'h04);
        // R6 receiver disabled on channel 1: byte refused
        rx_push(1, 8'h33);
        check("R6 disabled refuse", {14'd0, rx_ready}, 16'b01);
        rreg(1, 4'd0, d);
        check("R6 disabled status", {8'd0, d}, 16'h04);

        // R10 R12 receive interrupt modes
        for (int m = 0; m < 4; m++) begin
            wreg(0, 4'd1, 8'h01 | 8'(m << 3));
            rx_push(0, 8'h10 + 8'(m));
            check($sformatf("R10 mode %0d", m), {15'd0, irq}, {15'd0, 1'(m == 1 || m == 2)});
            bus_read(3'b010, d);
            check("R7 byte per mode", {8'd0, d}, {8'd0, 8'h10 + 8'(m)});
            check("R7 irq cleared by read", {15'd0, irq}, 16'd0);
        end
        // R8 no master enable
        wreg(0, 4'd1, 8'h08);
        rx_push(0, 8'h44);
        check("R8 masked", {15'd0, irq}, 16'd0);
        bus_read(3'b010, d);

        // R9 R5 transmit path
        wreg(0, 4'd5, 8'h08);
        wreg(0, 4'd1, 8'h03);
        check("R9 idle no pending", {15'd0, irq}, 16'd0);
        pulse_done(0);
        check("R9 tx pending irq", {15'd0, irq}, 16'd1);
        bus_write(3'b010, 8'h5A);
        check("R5 strobe", {14'd0, tx_strobe}, 16'b01);
        check("R5 tx byte", tx_data, 16'h005A);
        check("R9 write clears", {15'd0, irq}, 16'd0);
        rreg(0, 4'd0, d);
        check("R9 empty bit clear", {8'd0, d}, 16'h00);
        pulse_done(0);
        check("R9 pending again", {15'd0, irq}, 16'd1);
        wreg(0, 4'd5, 8'h00);
        bus_write(3'b011, 8'hC3);
        check("R5 disabled no strobe", {14'd0, tx_strobe}, 16'b00);
        check("R5 disabled keeps pending", {15'd0, irq}, 16'd1);
        wreg(0, 4'd1, 8'h00);
        check("R8 off", {15'd0, irq}, 16'd0);

        // R11 R12 break on channel 1
        wreg(1, 4'd15, 8'h80);
        wreg(1, 4'd1, 8'h01);
        pulse_break(1);
        check("R11 break irq", {15'd0, irq}, 16'd1);
        rreg(1, 4'd0, d);
        check("R11 break status", {8'd0, d}, 16'h84);
        check("R11 cleared by read", {15'd0, irq}, 16'd0);
        rreg(1, 4'd0, d);
        check("R11 status after", {8'd0, d}, 16'h04);

        // R4 reset commands
        wreg(0, 4'd3, 8'h01);
        wreg(1, 4'd3, 8'h01);
        check("R4 both enabled", {14'd0, rx_ready}, 16'b11);
        rx_push(0, 8'h77);
        wreg(0, 4'd9, 8'h00);
        check("R4 null command", {14'd0, rx_ready}, 16'b10);
        wreg(0, 4'd9, 8'h40);
        check("R4 second reset", {14'd0, rx_ready}, 16'b00);
        rreg(0, 4'd0, d);
        check("R4 first untouched", {8'd0, d}, 16'h05);
        wreg(1, 4'd3, 8'h01);
        wreg(1, 4'd9, 8'h80);
        rreg(0, 4'd0, d);
        check("R4 first reset status", {8'd0, d}, 16'h04);
        check("R4 first reset ready", {14'd0, rx_ready}, 16'b10);
        wreg(0, 4'd3, 8'h01);
        wreg(1, 4'd9, 8'hC0);
        check("R4 both reset", {14'd0, rx_ready}, 16'b00);

        // R3 reset mid-run
        wreg(0, 4'd3, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R3 mid-run ready", {14'd0, rx_ready}, 16'd0);
        rst_n = 1'b1;
        rreg(1, 4'd0, d);
        check("R3 mid-run status", {8'd0, d}, 16'h04);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule